// File: doc/BRIEF.md
# Serial Keyboard Link Responder

This block is the keyboard end of a byte-wide serial keyboard link. Key events arrive already mapped to 7-bit keycodes. Each event becomes one byte in a receive queue that holds 256 bytes. The host reads that queue through the data port of a serial channel. Bytes sent by the host are decoded as keyboard commands, and a command that asks for an answer loads a fixed reply into the same queue. The queue is flushed first.

Caps lock and num lock arrive from the host side as ordinary press and release events. Each one passes through a two-bit filter, so the link carries the toggle-style sequence that a latching lock key would produce.

All updates in one cycle happen in a fixed order:
1. A data read pops the head byte.
2. A command reply flushes the queue and writes its bytes.
3. The key byte from the same cycle is appended after the reply.

Top module: `kbd_link_responder`

## Requirements
- R1: When a key event is accepted, one byte is enqueued. Bits 6:0 hold the keycode. Bit 7 is 0 for a press and 1 for a release.
- R2: Each of the two lock keys (caps lock keycode 0x77, num lock keycode 0x62) keeps a 2-bit state that starts at 0. A press toggles bit 0. The event is dropped when the new state equals 2.
- R3: For the same lock keys, a release toggles bit 1. The event is dropped when the new state equals 3.
- R4: Command byte 0x01 empties the queue, then enqueues 0xFF, 0x04 and 0x7F in that order.
- R5: Command byte 0x0E arms an LED mode. The next accepted command byte, whatever its value, is discarded with no reply, and the LED mode ends.
- R6: Command bytes 0x07 and 0x0F each empty the queue, then enqueue 0xFE followed by 0x21.
- R7: Any other command byte leaves the queue contents and the LED mode unchanged.
- R8: A command byte has no effect unless `tx_enable` is 1 and `chan_disabled` is 0.
- R9: The queue stores at most 256 bytes. A byte pushed while the queue is full is lost, and the stored bytes are unchanged.
- R10: `rx_avail` is 1 exactly while the queue holds data. `rd_data` shows the head byte, or 0 when the queue is empty. A read pops that byte. A read of an empty queue returns 0 and changes nothing.
- R11: `rx_event` pulses for one cycle after any cycle that stored at least one byte. It also pulses after a cycle whose read popped a byte and left the queue non-empty.
- R12: When a key event and a command reply occur in the same cycle, the reply (including its flush) is applied first and the key byte follows it. A read in that cycle pops before the flush.
- R13: A synchronous reset empties the queue, ends LED mode and returns both lock states to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_vld | input | 1 | Key event strobe |
| key_code | input | 7 | Keycode of the event |
| key_down | input | 1 | 1 for press, 0 for release |
| host_wr | input | 1 | Host command byte strobe |
| host_byte | input | 8 | Host command byte |
| tx_enable | input | 1 | Transmit path enabled |
| chan_disabled | input | 1 | Channel disabled, commands ignored |
| data_rd | input | 1 | Data port read, pops one byte |
| rd_data | output | 8 | Head byte of the queue, 0 when empty |
| rx_avail | output | 1 | Queue holds at least one byte |
| rx_event | output | 1 | Receive event pulse |

## Verification
The assertions check these properties on every cycle:
- the occupancy never exceeds the depth;
- a receive event always coincides with available data;
- after a flush the queue holds no more than one cycle's pushes;
- an empty read changes nothing;
- the lock states toggle the correct bit;
- LED mode swallows a byte and then ends;
- gated command bytes leave the LED mode alone.

Only the bench scenarios can show the rest:
- the exact reply byte sequences;
- the dropped lock events;
- the ordering of a reply against a key byte in the same cycle;
- loss of bytes at 256 entries;
- the effect of reset on lock and LED state.

// File: rtl/kbdl_pkg.sv
package kbdl_pkg;
   typedef logic [7:0] kbyte_t;

   localparam kbyte_t CMD_IDENT   = 8'h01;
   localparam kbyte_t CMD_LEDSET  = 8'h0E;
   localparam kbyte_t CMD_LAYOUT0 = 8'h07;
   localparam kbyte_t CMD_LAYOUT1 = 8'h0F;

   localparam kbyte_t IDENT_HEAD  = 8'hFF;
   localparam kbyte_t IDENT_KIND  = 8'h04;
   localparam kbyte_t IDENT_END   = 8'h7F;
   localparam kbyte_t LAYOUT_HEAD = 8'hFE;
   localparam kbyte_t LAYOUT_CODE = 8'h21;

   localparam int REPLY_MAX = 3;

   typedef enum logic [1:0] {
      REPLY_NONE,
      REPLY_IDENT,
      REPLY_LAYOUT
   } reply_e;
endpackage

// File: rtl/kbdl_lock_filter.sv
module kbdl_lock_filter #(
   parameter int               KEY_W = 7,
   parameter logic [KEY_W-1:0] CODE  = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ev_vld,
   input  logic [KEY_W-1:0] ev_code,
   input  logic             ev_down,
   output logic             drop
);
   logic [1:0] st_q, st_d;
   logic       hit;

   assign hit = ev_vld && (ev_code == CODE);

   always_comb begin
      st_d = st_q;
      drop = 1'b0;
      if (hit) begin
         if (ev_down) begin
            st_d = st_q ^ 2'b01;
            drop = (st_d == 2'd2);
         end else begin
            st_d = st_q ^ 2'b10;
            drop = (st_d == 2'd3);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= 2'd0;
      else     st_q <= st_d;
   end

   a_r2_press_toggles: assert property (@(posedge clk) disable iff (rst)
      (hit && ev_down) |=> (st_q[0] != $past(st_q[0])) && (st_q[1] == $past(st_q[1])));

   a_r3_release_toggles: assert property (@(posedge clk) disable iff (rst)
      (hit && !ev_down) |=> (st_q[1] != $past(st_q[1])) && (st_q[0] == $past(st_q[0])));
endmodule

// File: rtl/kbdl_cmd_decoder.sv
module kbdl_cmd_decoder
   import kbdl_pkg::*;
#(
   parameter int NREP = REPLY_MAX
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cmd_vld,
   input  kbyte_t                    cmd_byte,
   input  logic                      tx_en,
   input  logic                      chan_off,
   output logic                      flush,
   output logic [NREP-1:0]           reply_vld,
   output logic [NREP-1:0][7:0]      reply_byte
);
   logic   led_q, led_d;
   logic   fire;
   reply_e kind;

   if (NREP < 3) begin : g_bad_nrep
      $error("kbdl_cmd_decoder: NREP must be at least 3");
   end

   assign fire = cmd_vld && tx_en && !chan_off;

   always_comb begin
      led_d = led_q;
      kind  = REPLY_NONE;
      if (fire) begin
         if (led_q) begin
            led_d = 1'b0;
         end else begin
            unique case (cmd_byte)
               CMD_IDENT:                kind  = REPLY_IDENT;
               CMD_LEDSET:               led_d = 1'b1;
               CMD_LAYOUT0, CMD_LAYOUT1: kind  = REPLY_LAYOUT;
               default:                  kind  = REPLY_NONE;
            endcase
         end
      end
   end

   always_comb begin
      reply_vld  = '0;
      reply_byte = '0;
      flush      = 1'b0;
      case (kind)
         REPLY_IDENT: begin
            flush         = 1'b1;
            reply_vld[2:0] = 3'b111;
            reply_byte[0] = IDENT_HEAD;
            reply_byte[1] = IDENT_KIND;
            reply_byte[2] = IDENT_END;
         end
         REPLY_LAYOUT: begin
            flush         = 1'b1;
            reply_vld[1:0] = 2'b11;
            reply_byte[0] = LAYOUT_HEAD;
            reply_byte[1] = LAYOUT_CODE;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) led_q <= 1'b0;
      else     led_q <= led_d;
   end

   a_r5_led_swallow: assert property (@(posedge clk) disable iff (rst)
      (led_q && fire) |-> (reply_vld == '0) && !flush);

   a_r5_led_leaves: assert property (@(posedge clk) disable iff (rst)
      (led_q && fire) |=> !led_q);

   a_r8_gated_no_change: assert property (@(posedge clk) disable iff (rst)
      (cmd_vld && !(tx_en && !chan_off)) |=> $stable(led_q));
endmodule

// File: rtl/kbdl_byte_queue.sv
module kbdl_byte_queue #(
   parameter int DEPTH = 256,
   parameter int LANES = 4,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      flush,
   input  logic [LANES-1:0]          push_vld,
   input  logic [LANES-1:0][DW-1:0]  push_data,
   input  logic                      pop,
   output logic [DW-1:0]             rd_data,
   output logic                      not_empty,
   output logic                      rx_event
);
   logic [DW-1:0]            mem [DEPTH];
   logic [AW-1:0]            rptr_q, wptr_q, rptr_d, wptr_d, w_base;
   logic [CW-1:0]            cnt_q, cnt_d, c_after, c_base;
   logic [LANES-1:0]         acc;
   logic [LANES-1:0][AW-1:0] widx;
   logic                     pop_take, ev_d;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("kbdl_byte_queue: DEPTH must be a power of two");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("kbdl_byte_queue: LANES must be positive");
   end

   always_comb begin
      logic [CW-1:0] c_run;
      pop_take = pop && (cnt_q != '0);
      c_after  = cnt_q - CW'(pop_take);
      if (flush) begin
         rptr_d = '0;
         w_base = '0;
         c_base = '0;
      end else begin
         rptr_d = rptr_q + AW'(pop_take);
         w_base = wptr_q;
         c_base = c_after;
      end
      c_run = c_base;
      for (int i = 0; i < LANES; i++) begin
         acc[i]  = push_vld[i] && (c_run < CW'(DEPTH));
         widx[i] = w_base + AW'(c_run - c_base);
         if (acc[i]) c_run = c_run + CW'(1);
      end
      cnt_d  = c_run;
      wptr_d = w_base + AW'(c_run - c_base);
      ev_d   = (c_run != c_base) || (pop_take && (c_after != '0));
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (!rst && acc[i]) mem[widx[i]] <= push_data[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rptr_q   <= '0;
         wptr_q   <= '0;
         cnt_q    <= '0;
         rx_event <= 1'b0;
      end else begin
         rptr_q   <= rptr_d;
         wptr_q   <= wptr_d;
         cnt_q    <= cnt_d;
         rx_event <= ev_d;
      end
   end

   assign not_empty = (cnt_q != '0);
   assign rd_data   = not_empty ? mem[rptr_q] : '0;

   a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(DEPTH));

   a_r11_event_has_data: assert property (@(posedge clk) disable iff (rst)
      rx_event |-> not_empty);

   a_r12_flush_bound: assert property (@(posedge clk) disable iff (rst)
      flush |=> cnt_q <= CW'(LANES));

   a_r10_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
      (pop && cnt_q == '0 && !flush && push_vld == '0) |=> cnt_q == '0);
endmodule

// File: rtl/kbd_link_responder.sv
module kbd_link_responder
   import kbdl_pkg::*;
#(
   parameter int                          KEY_W      = 7,
   parameter int                          DEPTH      = 256,
   parameter int                          NUM_LOCKS  = 2,
   parameter logic [NUM_LOCKS*KEY_W-1:0]  LOCK_CODES = {7'h62, 7'h77},
   localparam int                         DW         = 8,
   localparam int                         LANES      = REPLY_MAX + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             key_vld,
   input  logic [KEY_W-1:0] key_code,
   input  logic             key_down,
   input  logic             host_wr,
   input  logic [7:0]       host_byte,
   input  logic             tx_enable,
   input  logic             chan_disabled,
   input  logic             data_rd,
   output logic [7:0]       rd_data,
   output logic             rx_avail,
   output logic             rx_event
);
   logic [NUM_LOCKS-1:0]          lock_drop;
   logic                          key_push;
   logic [DW-1:0]                 key_byte;
   logic                          flush;
   logic [REPLY_MAX-1:0]          reply_vld;
   logic [REPLY_MAX-1:0][7:0]     reply_byte;
   logic [LANES-1:0]              push_vld;
   logic [LANES-1:0][DW-1:0]      push_data;

   if (KEY_W + 1 != DW) begin : g_bad_keyw
      $error("kbd_link_responder: KEY_W must leave exactly one flag bit");
   end

   for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
      kbdl_lock_filter #(
         .KEY_W (KEY_W),
         .CODE  (LOCK_CODES[g*KEY_W +: KEY_W])
      ) u_filter (
         .clk     (clk),
         .rst     (rst),
         .ev_vld  (key_vld),
         .ev_code (key_code),
         .ev_down (key_down),
         .drop    (lock_drop[g])
      );
   end

   assign key_push = key_vld && (lock_drop == '0);
   assign key_byte = {~key_down, key_code};

   kbdl_cmd_decoder #(.NREP(REPLY_MAX)) u_cmd (
      .clk        (clk),
      .rst        (rst),
      .cmd_vld    (host_wr),
      .cmd_byte   (host_byte),
      .tx_en      (tx_enable),
      .chan_off   (chan_disabled),
      .flush      (flush),
      .reply_vld  (reply_vld),
      .reply_byte (reply_byte)
   );

   // Reply bytes take the low lanes, the key byte the last lane (R12 ordering).
   assign push_vld  = {key_push, reply_vld};
   assign push_data = {key_byte, reply_byte};

   kbdl_byte_queue #(
      .DEPTH (DEPTH),
      .LANES (LANES),
      .DW    (DW)
   ) u_queue (
      .clk       (clk),
      .rst       (rst),
      .flush     (flush),
      .push_vld  (push_vld),
      .push_data (push_data),
      .pop       (data_rd),
      .rd_data   (rd_data),
      .not_empty (rx_avail),
      .rx_event  (rx_event)
   );

   a_r1_release_flag: assert property (@(posedge clk) disable iff (rst)
      (key_vld && !key_down && !flush && !rx_avail && !data_rd && key_push) |=> rd_data[7]);
endmodule

// File: tb/kbd_link_responder_tb_top.sv
`timescale 1ns/1ps
module kbd_link_responder_tb_top;
   localparam logic [6:0] CAPS = 7'h77;
   localparam logic [6:0] NUML = 7'h62;
   localparam int         QMAX = 256;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       key_vld = 1'b0;
   logic [6:0] key_code = '0;
   logic       key_down = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_byte = '0;
   logic       tx_enable = 1'b1;
   logic       chan_disabled = 1'b0;
   logic       data_rd = 1'b0;
   logic [7:0] rd_data;
   logic       rx_avail;
   logic       rx_event;

   always #2 clk = ~clk;

   kbd_link_responder dut_i (
      .clk(clk), .rst(rst), .key_vld(key_vld), .key_code(key_code),
      .key_down(key_down), .host_wr(host_wr), .host_byte(host_byte),
      .tx_enable(tx_enable), .chan_disabled(chan_disabled), .data_rd(data_rd),
      .rd_data(rd_data), .rx_avail(rx_avail), .rx_event(rx_event)
   );

   int    nchk = 0;
   int    nerr = 0;
   int    cyc  = 0;
   string phase = "R13";

   byte unsigned mq[$];
   int           lk[2];
   bit           mled;
   bit           mev;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
      end
   endtask

   task automatic compare();
      int exp_rd;
      exp_rd = (mq.size() != 0) ? int'(mq[0]) : 0;
      chk(int'(rd_data) == exp_rd, "rd_data", int'(rd_data), exp_rd);
      chk(rx_avail == (mq.size() != 0), "rx_avail", int'(rx_avail), int'(mq.size() != 0));
      chk(rx_event == mev, "rx_event", int'(rx_event), int'(mev));
   endtask

   function automatic void model_reset();
      mq.delete();
      lk[0] = 0; lk[1] = 0;
      mled = 0; mev = 0;
   endfunction

   function automatic void model(input bit kv, input logic [6:0] kc, input bit kd,
                                 input bit hw, input logic [7:0] hb, input bit te,
                                 input bit cd, input bit pop);
      bit pushed = 0, took = 0, remain = 0, drop = 0;
      int idx;
      if (pop && mq.size() != 0) begin
         void'(mq.pop_front());
         took = 1;
         remain = (mq.size() != 0);
      end
      if (hw && te && !cd) begin
         if (mled) mled = 0;
         else begin
            case (hb)
               8'h01: begin
                  mq.delete();
                  mq.push_back(8'hFF); mq.push_back(8'h04); mq.push_back(8'h7F);
                  pushed = 1;
               end
               8'h0E: mled = 1;
               8'h07, 8'h0F: begin
                  mq.delete();
                  mq.push_back(8'hFE); mq.push_back(8'h21);
                  pushed = 1;
               end
               default: ;
            endcase
         end
      end
      if (kv) begin
         idx = (kc == CAPS) ? 0 : (kc == NUML) ? 1 : -1;
         if (idx >= 0) begin
            if (kd) begin lk[idx] ^= 1; drop = (lk[idx] == 2); end
            else    begin lk[idx] ^= 2; drop = (lk[idx] == 3); end
         end
         if (!drop && mq.size() < QMAX) begin
            mq.push_back({~kd, kc});
            pushed = 1;
         end
      end
      mev = pushed || (took && remain);
   endfunction

   task automatic step(input bit kv, input logic [6:0] kc, input bit kd,
                       input bit hw, input logic [7:0] hb, input bit te,
                       input bit cd, input bit pop);
      compare();
      key_vld = kv; key_code = kc; key_down = kd;
      host_wr = hw; host_byte = hb; tx_enable = te; chan_disabled = cd;
      data_rd = pop;
      @(posedge clk);
      model(kv, kc, kd, hw, hb, te, cd, pop);
      @(negedge clk);
      key_vld = 0; host_wr = 0; data_rd = 0; tx_enable = 1; chan_disabled = 0;
   endtask

   task automatic key(input logic [6:0] kc, input bit kd);
      step(1, kc, kd, 0, 8'h00, 1, 0, 0);
   endtask
   task automatic cmd(input logic [7:0] b, input bit te = 1, input bit cd = 0);
      step(0, 7'h00, 0, 1, b, te, cd, 0);
   endtask
   task automatic rd();
      step(0, 7'h00, 0, 0, 8'h00, 1, 0, 1);
   endtask
   task automatic idle();
      step(0, 7'h00, 0, 0, 8'h00, 1, 0, 0);
   endtask
   task automatic drain(input int n);
      for (int i = 0; i < n; i++) rd();
   endtask
   task automatic reset_pulse();
      @(negedge clk); rst = 1;
      @(posedge clk); model_reset();
      @(negedge clk); rst = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nerr++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      phase = "R13"; compare();

      // R1: press and release of plain keys, R11 events
      phase = "R1";
      key(7'h12, 1); key(7'h12, 0); key(7'h05, 1); idle();
      phase = "R11"; rd(); rd(); rd(); idle();

      // R2 / R3: caps lock and num lock filtering
      phase = "R2"; key(CAPS, 1); phase = "R3"; key(CAPS, 0);
      phase = "R2"; key(CAPS, 1); phase = "R3"; key(CAPS, 0);
      phase = "R2"; key(NUML, 1); key(NUML, 1);
      phase = "R3"; key(NUML, 0); key(NUML, 0);
      drain(6);

      // R4: identify reply after flushing old bytes
      phase = "R4"; key(7'h20, 1); key(7'h21, 1); cmd(8'h01); drain(4);
      // R5: LED mode swallows next byte even if it is a reply command
      phase = "R5"; cmd(8'h0E); cmd(8'h01); idle(); cmd(8'h07); drain(3);
      // R6: both layout queries
      phase = "R6"; key(7'h30, 1); cmd(8'h07); rd(); cmd(8'h0F); drain(3);
      // R7: unknown commands ignored
      phase = "R7"; key(7'h31, 0); cmd(8'h55); cmd(8'h00); cmd(8'hFF); idle(); drain(2);
      // R8: gated commands
      phase = "R8"; key(7'h32, 1); cmd(8'h01, 0, 0); cmd(8'h0E, 1, 1); cmd(8'h07, 0, 1);
      cmd(8'h01); drain(4);

      // R9: overflow at 256, R10: pops past empty return 0
      phase = "R9";
      for (int i = 0; i < 260; i++) key(7'(i % 64), i[0]);
      phase = "R10"; drain(258); rd(); idle();

      // R12: same-cycle reply and key, and pop with reply
      phase = "R12";
      key(7'h40, 1);
      step(1, 7'h41, 0, 1, 8'h01, 1, 0, 0);
      step(1, 7'h42, 1, 1, 8'h0F, 1, 0, 1);
      drain(4);
      step(1, 7'h43, 1, 0, 8'h00, 1, 0, 1);
      drain(2);

      // R13: reset clears queue, LED mode and lock state
      phase = "R13";
      key(CAPS, 1); key(CAPS, 0); cmd(8'h0E); key(7'h44, 1);
      reset_pulse(); compare();
      key(CAPS, 1); cmd(8'h01); drain(4);

      idle();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule